// File: doc/BRIEF.md
# Command Mailbox with Doorbell Handshake

This block is the device side of a host-to-device command mailbox. The host reaches it over a simple word-addressed register bus. To issue a command, the host confirms that the doorbell is clear. It then loads an opcode, an input length and an input payload, and rings the doorbell. The device runs the command against the payload buffer, writes a return code and an output length, and drops the doorbell. The host polls the doorbell and, once it is clear, reads the results. A command takes a fixed number of cycles, well inside any host-side busy timeout.

Every register the host could change is frozen while a command is in flight. Once the doorbell falls, the device leaves its results alone until the host rings again. A small stub engine stands in for real command handling. It can echo the payload, XOR a tag into every word, or report a length that the host requests. Output lengths are clamped to the usable buffer size. A reset timer raises a mailbox-ready flag. The host reads that flag, together with fatal-error and firmware-halt flags, in a device status word.

Top module: `mbox_device`

## Requirements
- R1: After reset the doorbell reads 0, the return code reads 0, the length reads 0, the ready bit (device status bit 0) reads 0, and the capability word at address 0 reads SIZE_EXP in bits [4:0] (8 by default).
- R2: The ready output rises exactly READY_CYCLES clock edges after reset is released and then stays high. A write of 1 to the doorbell before ready is ignored.
- R3: Word address map: 0 capability, 1 control (bit 0 doorbell), 2 opcode [15:0], 3 input/output length [20:0], 4 return code [15:0], 5 device status. Addresses with the top bit set select payload word (address minus 64 by default). Opcode, length and payload words read back what the host wrote while the mailbox is idle, and length bits above 20 are dropped.
- R4: Writing 1 to control bit 0 while the doorbell is clear sets it. Writing 0 never clears it, and writing 1 again while it is set does not restart it. The doorbell falls exactly WORDS+2 clock edges after the edge that set it (66 by default, WORDS = 2^(SIZE_EXP-2)).
- R5: While the doorbell is set, host writes to the opcode, the length and the payload are dropped.
- R6: Opcode 0x0001 (echo) leaves the payload unchanged, returns code 0, and sets the length to the input length clamped to the usable size, min(2^SIZE_EXP, 1 MiB) bytes.
- R7: Opcode 0x0002 (tag) XORs TAG_MASK (0x5A5A5A5A by default) into every payload word, returns code 0, and sets the clamped input length.
- R8: Opcode 0x0003 (size) leaves the payload unchanged, returns code 0, and sets the length to bits [20:0] of payload word 0, clamped to the usable size.
- R9: Any other opcode returns code 0x0001 with length 0.
- R10: After the doorbell falls, the device does not alter the return code, the length or the payload before the next doorbell.
- R11: Device status bit 1 mirrors the fatal-error input and bit 2 mirrors the firmware-halt input.
- R12: A host write whose capturing edge is the completion edge (the one that clears the doorbell) is dropped, and the engine's result stands. The same write one edge later is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostAddr | input | SIZE_EXP-1 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostWe | input | 1 | Host write strobe, captured on the rising edge |
| hostRdata | output | 32 | Host read data, combinational from the address |
| devFatal | input | 1 | Device fatal-error flag, reported in device status |
| fwHalt | input | 1 | Firmware-halted flag, reported in device status |
| mboxReady | output | 1 | Mailbox ready indication |

## Verification
Two things can land on the same clock edge: the engine posting its result and clearing the doorbell, and a host write to the length or payload register. The bench counts the cycles from the doorbell-setting edge so that a host write is captured exactly on the completion edge. It then checks that the engine's length and the original payload word survive. Repeating the same write one edge later checks that the mailbox has really reopened. A second overlap, between a repeated doorbell write and a command in flight, is judged by timing the total busy span.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int OPC_W = 16;
  localparam int LEN_W = 21;
  localparam int RC_W  = 16;

  localparam int ADDR_CAP   = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_OPC   = 2;
  localparam int ADDR_LEN   = 3;
  localparam int ADDR_RC    = 4;
  localparam int ADDR_DEVST = 5;

  localparam logic [OPC_W-1:0] OPC_ECHO = 16'h0001;
  localparam logic [OPC_W-1:0] OPC_TAG  = 16'h0002;
  localparam logic [OPC_W-1:0] OPC_SIZE = 16'h0003;

  localparam logic [RC_W-1:0] RC_OK    = 16'h0000;
  localparam logic [RC_W-1:0] RC_UNSUP = 16'h0001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } engState_t;

  // strobes from the command engine to the register datapath
  typedef struct packed {
    logic             xorWord;
    logic             finish;
    logic [RC_W-1:0]  rc;
    logic [LEN_W-1:0] len;
  } engStrobe_t;
endpackage

// File: rtl/mbox_ready_timer.sv
module mbox_ready_timer #(
  parameter int READY_CYCLES = 16,
  localparam int CNT_W = $clog2(READY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic mboxReady
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      mboxReady <= 1'b0;
    end else if (!mboxReady) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(READY_CYCLES - 1)) mboxReady <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_engine.sv
module mbox_engine
  import mbox_pkg::*;
#(
  parameter int SIZE_EXP = 8,
  localparam int PW = SIZE_EXP - 2,
  localparam int WORDS = 1 << PW,
  localparam int USE_BYTES = (SIZE_EXP > 20) ? (1 << 20) : (1 << SIZE_EXP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bell,
  input  logic [OPC_W-1:0] opcode,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [LEN_W-1:0] wordLen,
  output engStrobe_t       strobe,
  output logic [PW-1:0]    engIdx
);
  engState_t state;

  function automatic logic [LEN_W-1:0] clampLen(input logic [LEN_W-1:0] v);
    return (v > LEN_W'(USE_BYTES)) ? LEN_W'(USE_BYTES) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      engIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (bell) begin
            state  <= ST_RUN;
            engIdx <= '0;
          end
        end
        ST_RUN: begin
          engIdx <= engIdx + 1'b1;
          if (engIdx == PW'(WORDS - 1)) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.xorWord = (state == ST_RUN) && (opcode == OPC_TAG);
    strobe.finish  = (state == ST_DONE);
    case (opcode)
      OPC_ECHO, OPC_TAG: begin
        strobe.rc  = RC_OK;
        strobe.len = clampLen(cmdLen);
      end
      OPC_SIZE: begin
        strobe.rc  = RC_OK;
        strobe.len = clampLen(wordLen);
      end
      default: begin
        strobe.rc  = RC_UNSUP;
        strobe.len = '0;
      end
    endcase
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int SIZE_EXP = 8,
  parameter logic [31:0] TAG_MASK = 32'h5A5A_5A5A,
  localparam int PW = SIZE_EXP - 2,
  localparam int WORDS = 1 << PW,
  localparam int AW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    hostAddr,
  input  logic [31:0]      hostWdata,
  input  logic             hostWe,
  output logic [31:0]      hostRdata,
  input  logic             devFatal,
  input  logic             fwHalt,
  input  logic             mboxReady,
  input  engStrobe_t       strobe,
  input  logic [PW-1:0]    engIdx,
  output logic             bell,
  output logic [OPC_W-1:0] opcode,
  output logic [LEN_W-1:0] cmdLen,
  output logic [RC_W-1:0]  retCode,
  output logic [LEN_W-1:0] wordLen
);
  logic [31:0] payload [WORDS];

  logic          isPay;
  logic [PW-1:0] payIdx;
  logic          hostOpen;

  assign isPay    = hostAddr[AW-1];
  assign payIdx   = hostAddr[PW-1:0];
  assign hostOpen = hostWe && !bell;
  assign wordLen  = payload[0][LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bell    <= 1'b0;
      opcode  <= '0;
      cmdLen  <= '0;
      retCode <= '0;
      for (int i = 0; i < WORDS; i++) payload[i] <= '0;
    end else begin
      if (hostOpen) begin
        if (isPay) begin
          payload[payIdx] <= hostWdata;
        end else begin
          case (hostAddr)
            AW'(ADDR_OPC):  opcode <= hostWdata[OPC_W-1:0];
            AW'(ADDR_LEN):  cmdLen <= hostWdata[LEN_W-1:0];
            AW'(ADDR_CTRL): if (hostWdata[0] && mboxReady) bell <= 1'b1;
            default: ;
          endcase
        end
      end
      if (strobe.xorWord) payload[engIdx] <= payload[engIdx] ^ TAG_MASK;
      if (strobe.finish) begin
        bell    <= 1'b0;
        retCode <= strobe.rc;
        cmdLen  <= strobe.len;
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    if (isPay) begin
      hostRdata = payload[payIdx];
    end else begin
      case (hostAddr)
        AW'(ADDR_CAP):   hostRdata = 32'(SIZE_EXP);
        AW'(ADDR_CTRL):  hostRdata = {31'b0, bell};
        AW'(ADDR_OPC):   hostRdata = {{(32-OPC_W){1'b0}}, opcode};
        AW'(ADDR_LEN):   hostRdata = {{(32-LEN_W){1'b0}}, cmdLen};
        AW'(ADDR_RC):    hostRdata = {{(32-RC_W){1'b0}}, retCode};
        AW'(ADDR_DEVST): hostRdata = {29'b0, fwHalt, devFatal, mboxReady};
        default:         hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_device.sv
module mbox_device
  import mbox_pkg::*;
#(
  parameter int SIZE_EXP = 8,
  parameter logic [31:0] TAG_MASK = 32'h5A5A_5A5A,
  parameter int READY_CYCLES = 16,
  localparam int PW = SIZE_EXP - 2,
  localparam int ADDR_W = SIZE_EXP - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic              hostWe,
  output logic [31:0]       hostRdata,
  input  logic              devFatal,
  input  logic              fwHalt,
  output logic              mboxReady
);
  engStrobe_t       strobe;
  logic [PW-1:0]    engIdx;
  logic             bell;
  logic [OPC_W-1:0] opcode;
  logic [LEN_W-1:0] cmdLen;
  logic [RC_W-1:0]  retCode;
  logic [LEN_W-1:0] wordLen;

  mbox_ready_timer #(.READY_CYCLES(READY_CYCLES)) uTimer (
    .clk(clk), .rst_n(rst_n), .mboxReady(mboxReady)
  );

  mbox_regs #(.SIZE_EXP(SIZE_EXP), .TAG_MASK(TAG_MASK)) uRegs (
    .clk(clk), .rst_n(rst_n),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostWe(hostWe), .hostRdata(hostRdata),
    .devFatal(devFatal), .fwHalt(fwHalt), .mboxReady(mboxReady),
    .strobe(strobe), .engIdx(engIdx),
    .bell(bell), .opcode(opcode), .cmdLen(cmdLen), .retCode(retCode), .wordLen(wordLen)
  );

  mbox_engine #(.SIZE_EXP(SIZE_EXP)) uEngine (
    .clk(clk), .rst_n(rst_n),
    .bell(bell), .opcode(opcode), .cmdLen(cmdLen), .wordLen(wordLen),
    .strobe(strobe), .engIdx(engIdx)
  );
endmodule

// File: rtl/mbox_device_chk.sv
module mbox_device_chk #(
  parameter int SIZE_EXP = 8,
  localparam int WORDS = 1 << (SIZE_EXP - 2),
  localparam int ADDR_W = SIZE_EXP - 1,
  localparam int USE_BYTES = (SIZE_EXP > 20) ? (1 << 20) : (1 << SIZE_EXP),
  localparam int BC_W = $clog2(WORDS + 3) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bell,
  input logic [15:0]       opcode,
  input logic [20:0]       cmdLen,
  input logic [15:0]       retCode,
  input logic              mboxReady,
  input logic              hostWe,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [31:0]       hostWdata
);
  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busyCnt <= '0;
    else if (bell) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  AST_BELL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bell) |-> $past(hostWe && (hostAddr == ADDR_W'(1)) && hostWdata[0] && mboxReady)); // R4

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bell |-> (busyCnt <= BC_W'(WORDS + 1))); // R4

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && $past(bell)) |-> ($stable(opcode) && $stable(cmdLen) && $stable(retCode))); // R5

  AST_IDLE_RC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bell && $past(!bell)) |-> $stable(retCode)); // R10

  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bell) |-> (cmdLen <= 21'(USE_BYTES))); // R6

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mboxReady) |-> mboxReady); // R2

  AST_NO_BELL_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !mboxReady |-> !bell); // R2
endmodule

bind mbox_device mbox_device_chk #(.SIZE_EXP(SIZE_EXP)) uChk (
  .clk(clk), .rst_n(rst_n), .bell(bell), .opcode(opcode), .cmdLen(cmdLen),
  .retCode(retCode), .mboxReady(mboxReady), .hostWe(hostWe),
  .hostAddr(hostAddr), .hostWdata(hostWdata)
);

// File: tb/sim_mbox_device.sv
`timescale 1ns/1ps
module sim_mbox_device;
  localparam int SIZE_EXP = 8;
  localparam int WORDS = 64;
  localparam int READY_CYCLES = 16;
  localparam logic [31:0] TAG = 32'h5A5A_5A5A;
  localparam int BUSY = WORDS + 2;
  localparam logic [6:0] A_CAP = 7'd0, A_CTRL = 7'd1, A_OPC = 7'd2, A_LEN = 7'd3,
                         A_RC = 7'd4, A_DEVST = 7'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostWe = 1'b0;
  logic [31:0] hostRdata;
  logic        devFatal = 1'b0;
  logic        fwHalt = 1'b0;
  logic        mboxReady;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int ringCyc = 0;
  int relCyc = 0;
  logic [31:0] v;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbox_device #(.SIZE_EXP(SIZE_EXP), .TAG_MASK(TAG), .READY_CYCLES(READY_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWdata(hostWdata), .hostWe(hostWe),
    .hostRdata(hostRdata), .devFatal(devFatal), .fwHalt(fwHalt), .mboxReady(mboxReady)
  );

  function automatic logic [6:0] payA(input int i);
    return 7'(64 + i);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic ring();
    wr(A_CTRL, 32'h1);
    ringCyc = cyc;
  endtask

  // returns the cycles from the ringing edge until the doorbell is seen clear
  task automatic waitIdle(output int elapsed);
    while (1) begin
      hostAddr = A_CTRL;
      #1;
      if (!hostRdata[0] || (cyc - ringCyc) > 1000) break;
      @(negedge clk);
    end
    elapsed = cyc - ringCyc;
  endtask

  task automatic fillPayload(input int base, input int step);
    for (int i = 0; i < WORDS; i++) wr(payA(i), 32'(base + i * step));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    relCyc = cyc;
    rd(A_CTRL, v);  chk("R1 doorbell", v, 32'h0);
    rd(A_RC, v);    chk("R1 retcode", v, 32'h0);
    rd(A_LEN, v);   chk("R1 length", v, 32'h0);
    rd(A_DEVST, v); chk("R1 ready bit", v, 32'h0);
    rd(A_CAP, v);   chk("R1 capability", v, 32'(SIZE_EXP));
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v);  chk("R2 doorbell before ready", v, 32'h0);
  endtask

  task automatic t_ready();
    int seen;
    seen = 0;
    while (!mboxReady && (cyc - relCyc) < 200) @(negedge clk);
    seen = cyc - relCyc;
    chk("R2 ready delay", 32'(seen), 32'(READY_CYCLES));
    repeat (5) @(negedge clk);
    chk("R2 ready sticky", {31'b0, mboxReady}, 32'h1);
  endtask

  task automatic t_readback();
    wr(A_OPC, 32'hABCD_1234); rd(A_OPC, v); chk("R3 opcode readback", v, 32'h0000_1234);
    wr(A_LEN, 32'hFFFF_FFFF); rd(A_LEN, v); chk("R3 length width", v, 32'h001F_FFFF);
    wr(payA(5), 32'hDEAD_BEEF); rd(payA(5), v); chk("R3 payload readback", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_echo();
    int el;
    fillPayload(1, 3);
    wr(A_OPC, 32'h1); wr(A_LEN, 32'd40);
    ring(); waitIdle(el);
    chk("R4 busy span", 32'(el), 32'(BUSY));
    rd(A_RC, v);  chk("R6 echo rc", v, 32'h0);
    rd(A_LEN, v); chk("R6 echo length", v, 32'd40);
    rd(payA(0), v);  chk("R6 echo word0", v, 32'd1);
    rd(payA(63), v); chk("R6 echo word63", v, 32'(1 + 63 * 3));
    wr(A_LEN, 32'd300);
    ring(); waitIdle(el);
    rd(A_LEN, v); chk("R6 echo length clamped", v, 32'd256);
  endtask

  task automatic t_tag();
    int el;
    int bad;
    fillPayload(0, 1);
    wr(A_OPC, 32'h2); wr(A_LEN, 32'd256);
    ring(); waitIdle(el);
    rd(A_RC, v);  chk("R7 tag rc", v, 32'h0);
    rd(A_LEN, v); chk("R7 tag length", v, 32'd256);
    bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      rd(payA(i), v);
      if (v !== (32'(i) ^ TAG)) bad++;
    end
    chk("R7 tag words wrong", 32'(bad), 32'h0);
  endtask

  task automatic t_size();
    int el;
    wr(A_OPC, 32'h3); wr(payA(0), 32'd1000);
    ring(); waitIdle(el);
    rd(A_LEN, v); chk("R8 size clamped", v, 32'd256);
    rd(payA(0), v); chk("R8 payload unchanged", v, 32'd1000);
    wr(payA(0), 32'hFFE0_0064);
    ring(); waitIdle(el);
    rd(A_LEN, v); chk("R8 size low bits", v, 32'd100);
    rd(A_RC, v);  chk("R8 rc", v, 32'h0);
  endtask

  task automatic t_unsup();
    int el;
    wr(A_OPC, 32'h7); wr(A_LEN, 32'd16);
    ring(); waitIdle(el);
    rd(A_RC, v);  chk("R9 unsupported rc", v, 32'h1);
    rd(A_LEN, v); chk("R9 unsupported length", v, 32'h0);
  endtask

  task automatic t_hold();
    // rc is 1 from the previous command; host traffic must not disturb results
    wr(payA(2), 32'h1111_2222);
    wr(A_OPC, 32'h1);
    repeat (20) @(negedge clk);
    rd(A_RC, v);    chk("R10 rc held", v, 32'h1);
    rd(A_LEN, v);   chk("R10 length held", v, 32'h0);
    rd(payA(2), v); chk("R10 payload held", v, 32'h1111_2222);
  endtask

  task automatic t_busyDrop();
    int el;
    wr(payA(1), 32'h0000_0A0A);
    wr(A_OPC, 32'h1); wr(A_LEN, 32'd8);
    ring();
    wr(A_OPC, 32'h2);
    wr(A_LEN, 32'd99);
    wr(payA(1), 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R4 write 0 keeps doorbell", v, 32'h1);
    wr(A_CTRL, 32'h1);
    waitIdle(el);
    chk("R4 re-ring no restart", 32'(el), 32'(BUSY));
    rd(A_OPC, v);   chk("R5 opcode write dropped", v, 32'h1);
    rd(A_LEN, v);   chk("R5 length write dropped", v, 32'd8);
    rd(payA(1), v); chk("R5 payload write dropped", v, 32'h0000_0A0A);
  endtask

  task automatic t_collision();
    int el;
    wr(payA(0), 32'h0000_AAAA);
    wr(A_OPC, 32'h1); wr(A_LEN, 32'd16);
    ring();
    repeat (WORDS) @(negedge clk);
    wr(A_LEN, 32'd77);   // captured on the completion edge
    rd(A_CTRL, v);  chk("R12 doorbell clear", v, 32'h0);
    rd(A_LEN, v);   chk("R12 engine length wins", v, 32'd16);
    ring();
    repeat (WORDS) @(negedge clk);
    wr(payA(0), 32'h0000_BBBB);
    waitIdle(el);
    rd(payA(0), v); chk("R12 payload write dropped", v, 32'h0000_AAAA);
    wr(A_LEN, 32'd77);
    rd(A_LEN, v);   chk("R12 later write accepted", v, 32'd77);
  endtask

  task automatic t_status();
    devFatal = 1'b1;
    rd(A_DEVST, v); chk("R11 fatal bit", v, 32'h3);
    fwHalt = 1'b1;
    rd(A_DEVST, v); chk("R11 halt bit", v, 32'h7);
    devFatal = 1'b0; fwHalt = 1'b0;
    rd(A_DEVST, v); chk("R11 bits clear", v, 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ready();
    t_readback();
    t_echo();
    t_tag();
    t_size();
    t_unsup();
    t_hold();
    t_busyDrop();
    t_collision();
    t_status();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule